// File: doc/BRIEF.md
# Overcurrent Gate Guard

This block is the digital gate-enable and fault logic for a single power switch. A pulse-width command decides when the switch should conduct, and a comparator reports when the drain current is above its limit. The block passes the command through to a gate enable. It masks the comparator for a short blanking interval after each turn-on, so that the ringing of the switch node cannot cause a false trip. Once that interval is over, it cuts the gate on a real overcurrent.

Two recovery policies are available. In latched mode, a trip keeps the switch off and holds the fault flag. Only a long continuous low period on the command, or a reset, releases it. In cycle-by-cycle mode, a trip only cuts the rest of the current on-period, and the fault clears as soon as the command drops. A two-bit slew code picks the blanking length, and faster slew settings use shorter windows.

Top module: `ocp_gate_guard`

## Requirements
- R1: `pwm_in` and `oc_in` each pass through two synchronizing flops, and `gate_en` is registered. With no fault, `gate_en` rises on the third clock edge after `pwm_in` rises and stays high for as many cycles as `pwm_in` was high.
- R2: `oc_in` is ignored for a blanking window of L cycles, counted from the first cycle in which the synchronized command is seen high. L is `BLANK_L0`..`BLANK_L3` for `slew_sel` = 0..3, and code 3 is the fastest setting with the shortest window. With `oc_in` held high before turn-on, `gate_en` is therefore high for exactly L cycles.
- R3: After the blanking window, a rising `oc_in` forces `gate_en` low on the third clock edge after the change, and sets `fault`.
- R4: In latched mode (`mode_sel` = 0), once tripped, `fault` stays 1 and `gate_en` stays 0 whatever `pwm_in` does, until a release.
- R5: In latched mode, `fault` clears once the synchronized command has been low for `LOW_CYCLES` consecutive cycles. `fault` is 0 on the (`LOW_CYCLES`+2)th edge after `pwm_in` falls, and still 1 one edge earlier. Normal switching then resumes.
- R6: In cycle-by-cycle mode (`mode_sel` = 1), a trip keeps `gate_en` low for the rest of the high period, even if `oc_in` drops. `fault` clears on the third edge after `pwm_in` falls.
- R7: In cycle-by-cycle mode, the next `pwm_in` pulse after the fault has cleared turns the switch on normally, for its full width.
- R8: In latched mode, a `pwm_in` high pulse during the low-time count restarts the count from zero, and the fault stays set.
- R9: A synchronous active-high `rst` leaves `gate_en` = 0 and `fault` = 0, and releases a latched fault.
- R10: `slew_sel` is sampled only while `gate_en` is 0. A code change that comes and goes while the gate is on has no effect on the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pwm_in | input | 1 | Asynchronous on/off command |
| oc_in | input | 1 | Asynchronous overcurrent comparator flag |
| mode_sel | input | 1 | 0 = latched recovery, 1 = cycle-by-cycle recovery |
| slew_sel | input | 2 | Slew code choosing the blanking length (3 = fastest, shortest) |
| gate_en | output | 1 | Registered gate enable |
| fault | output | 1 | Registered fault flag |

## Verification
Several rules are checked by assertions on every cycle:
- a trip clears the gate and raises the fault on the next edge;
- no fault can appear inside a blanking window;
- a latched fault holds until the low-time release;
- a cycle-by-cycle fault drops whenever the command is low;
- the gate and the fault are never high together;
- the sampled slew code stays frozen while the gate is on.

Other behaviours can only be shown by the bench's scenarios, because they depend on exact pulse widths and delays measured at the ports:
- the blanking length for each code in each mode;
- the three-edge latency from the inputs;
- the exact cycle of the low-time release, and its restart after a short pulse;
- the fact that a transient slew change has no effect.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic {
    OCP_LATCH = 1'b0,
    OCP_CYCLE = 1'b1
  } ocp_mode_e;

  localparam int unsigned SLEW_CODES = 4;
endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ocp_blank_timer.sv
module ocp_blank_timer #(
  parameter int unsigned BLANK_L0 = 20,
  parameter int unsigned BLANK_L1 = 14,
  parameter int unsigned BLANK_L2 = 9,
  parameter int unsigned BLANK_L3 = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rise,
  input  logic       gate_on,
  input  logic [1:0] slew_code,
  output logic       masked
);
  localparam int unsigned MAX_A   = (BLANK_L0 > BLANK_L1) ? BLANK_L0 : BLANK_L1;
  localparam int unsigned MAX_B   = (BLANK_L2 > BLANK_L3) ? BLANK_L2 : BLANK_L3;
  localparam int unsigned MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CW      = $clog2(MAX_LEN + 1);

  logic [1:0]    slew_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] len_sel;

  always_ff @(posedge clk) begin
    if (rst)           slew_q <= 2'd0;
    else if (!gate_on) slew_q <= slew_code;
  end

  always_comb begin
    case (slew_q)
      2'd0:    len_sel = CW'(BLANK_L0);
      2'd1:    len_sel = CW'(BLANK_L1);
      2'd2:    len_sel = CW'(BLANK_L2);
      default: len_sel = CW'(BLANK_L3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (rise)      cnt <= len_sel - CW'(1);
    else if (cnt != '0) cnt <= cnt - CW'(1);
  end

  assign masked = rise | (cnt != '0);

  initial begin
    AST_BLANK_NONZERO: assert (BLANK_L0 >= 1 && BLANK_L1 >= 1 && BLANK_L2 >= 1 && BLANK_L3 >= 1); // R2
  end

  AST_SLEW_FROZEN: assert property (@(posedge clk) disable iff (rst)
    gate_on |=> $stable(slew_q)); // R10
endmodule

// File: rtl/ocp_low_timer.sv
module ocp_low_timer #(
  parameter int unsigned LOW_CYCLES = 43750
) (
  input  logic clk,
  input  logic rst,
  input  logic pwm_s,
  output logic low_done
);
  localparam int unsigned LW = $clog2(LOW_CYCLES + 1);

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || pwm_s)                  low_cnt <= '0;
    else if (low_cnt != LW'(LOW_CYCLES)) low_cnt <= low_cnt + LW'(1);
  end

  assign low_done = !pwm_s && (low_cnt >= LW'(LOW_CYCLES - 1));

  AST_LOW_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
    low_done |-> ($past(pwm_s) == 1'b0) || (LOW_CYCLES <= 1)); // R8
endmodule

// File: rtl/ocp_fault_ctrl.sv
module ocp_fault_ctrl
  import ocp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pwm_s,
  input  logic      oc_s,
  input  logic      masked,
  input  logic      low_done,
  input  ocp_mode_e mode,
  output logic      gate_q,
  output logic      fault_q
);
  logic trip;

  assign trip = pwm_s & oc_s & !masked & !fault_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q <= 1'b0;
    end else if (trip) begin
      fault_q <= 1'b1;
    end else if (fault_q) begin
      if (mode == OCP_CYCLE && !pwm_s)     fault_q <= 1'b0;
      else if (mode == OCP_LATCH && low_done) fault_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= pwm_s & !fault_q & !trip;
  end

  AST_TRIP_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
    trip |=> (!gate_q && fault_q)); // R3
  AST_BLANK_NO_TRIP: assert property (@(posedge clk) disable iff (rst)
    (!fault_q && masked) |=> !fault_q); // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fault_q && mode == OCP_LATCH && !low_done) |=> (fault_q && !gate_q)); // R4
  AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (fault_q && mode == OCP_LATCH && low_done) |=> !fault_q); // R5
  AST_CBC_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (fault_q && mode == OCP_CYCLE && !pwm_s) |=> !fault_q); // R6
  AST_GATE_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(gate_q && fault_q)); // R4
endmodule

// File: rtl/ocp_gate_guard.sv
module ocp_gate_guard
  import ocp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BLANK_L0    = 20,
  parameter int unsigned BLANK_L1    = 14,
  parameter int unsigned BLANK_L2    = 9,
  parameter int unsigned BLANK_L3    = 5,
  parameter int unsigned LOW_CYCLES  = 43750
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwm_in,
  input  logic       oc_in,
  input  logic       mode_sel,
  input  logic [1:0] slew_sel,
  output logic       gate_en,
  output logic       fault
);
  logic [1:0] raw_in;
  logic [1:0] sync_out;
  logic       pwm_s;
  logic       oc_s;
  logic       pwm_d;
  logic       rise;
  logic       masked;
  logic       low_done;
  logic       gate_q;
  logic       fault_q;
  ocp_mode_e  mode;

  assign raw_in = {oc_in, pwm_in};
  assign mode   = ocp_mode_e'(mode_sel);

  ocp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_out)
  );

  assign pwm_s = sync_out[0];
  assign oc_s  = sync_out[1];

  always_ff @(posedge clk) begin
    if (rst) pwm_d <= 1'b0;
    else     pwm_d <= pwm_s;
  end

  assign rise = pwm_s & !pwm_d;

  ocp_blank_timer #(
    .BLANK_L0 (BLANK_L0),
    .BLANK_L1 (BLANK_L1),
    .BLANK_L2 (BLANK_L2),
    .BLANK_L3 (BLANK_L3)
  ) u_blank (
    .clk       (clk),
    .rst       (rst),
    .rise      (rise),
    .gate_on   (gate_q),
    .slew_code (slew_sel),
    .masked    (masked)
  );

  ocp_low_timer #(.LOW_CYCLES(LOW_CYCLES)) u_low (
    .clk      (clk),
    .rst      (rst),
    .pwm_s    (pwm_s),
    .low_done (low_done)
  );

  ocp_fault_ctrl u_fault (
    .clk      (clk),
    .rst      (rst),
    .pwm_s    (pwm_s),
    .oc_s     (oc_s),
    .masked   (masked),
    .low_done (low_done),
    .mode     (mode),
    .gate_q   (gate_q),
    .fault_q  (fault_q)
  );

  assign gate_en = gate_q;
  assign fault   = fault_q;

  AST_GATE_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
    gate_en |-> $past(pwm_s)); // R1
endmodule

// File: tb/test_ocp_gate_guard.sv
module test_ocp_gate_guard;
  localparam int unsigned L0 = 9;
  localparam int unsigned L1 = 6;
  localparam int unsigned L2 = 4;
  localparam int unsigned L3 = 2;
  localparam int unsigned LOWC = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwm_in = 1'b0;
  logic       oc_in = 1'b0;
  logic       mode_sel = 1'b0;
  logic [1:0] slew_sel = 2'd0;
  logic       gate_en;
  logic       fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ocp_gate_guard #(
    .SYNC_STAGES (2),
    .BLANK_L0    (L0),
    .BLANK_L1    (L1),
    .BLANK_L2    (L2),
    .BLANK_L3    (L3),
    .LOW_CYCLES  (LOWC)
  ) i_ocp_gate_guard (
    .clk      (clk),
    .rst      (rst),
    .pwm_in   (pwm_in),
    .oc_in    (oc_in),
    .mode_sel (mode_sel),
    .slew_sel (slew_sel),
    .gate_en  (gate_en),
    .fault    (fault)
  );

  function automatic int blank_len(input int code);
    case (code)
      0: return L0;
      1: return L1;
      2: return L2;
      default: return L3;
    endcase
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    pwm_in = 1'b0;
    oc_in = 1'b0;
    tick(4);
    rst = 1'b0;
    tick(2);
  endtask

  task automatic pulse_count(input int width, input int extra, output int cnt);
    cnt = 0;
    pwm_in = 1'b1;
    for (int k = 0; k < width + extra; k++) begin
      @(negedge clk);
      if (gate_en) cnt++;
      if (k + 1 == width) pwm_in = 1'b0;
    end
  endtask

  task automatic short_count(input int len, output int cnt);
    cnt = 0;
    oc_in = 1'b1;
    tick(3);
    pwm_in = 1'b1;
    for (int k = 0; k < len + 8; k++) begin
      @(negedge clk);
      if (gate_en) cnt++;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    do_reset();
    // R9: reset state
    check(gate_en == 1'b0, "R9 reset gate", int'(gate_en), 0);
    check(fault == 1'b0, "R9 reset fault", int'(fault), 0);

    // R1: clean pulses of several widths, latency then width
    mode_sel = 1'b0;
    for (int w = 1; w <= 7; w += 3) begin
      pwm_in = 1'b1;
      tick(2);
      check(gate_en == 1'b0, "R1 latency edge2", int'(gate_en), 0);
      tick(1);
      check(gate_en == 1'b1, "R1 latency edge3", int'(gate_en), 1);
      pwm_in = 1'b0;
      tick(6);
      pulse_count(w, 6, cnt);
      check(cnt == w, "R1 width", cnt, w);
    end

    // R2 R4 R6 R7: sweep modes and slew codes under a hard short
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 4; c++) begin
        do_reset();
        mode_sel = m[0];
        slew_sel = c[1:0];
        tick(4);
        short_count(blank_len(c), cnt);
        check(cnt == blank_len(c), "R2 blank width", cnt, blank_len(c));
        check(fault == 1'b1, "R3 fault after short", int'(fault), 1);
        oc_in = 1'b0;
        tick(5);
        check(gate_en == 1'b0, "R6 gate off rest of high", int'(gate_en), 0);
        pwm_in = 1'b0;
        tick(6);
        if (m == 1) begin
          check(fault == 1'b0, "R6 cbc fault clear", int'(fault), 0);
          pulse_count(10, 6, cnt);
          check(cnt == 10, "R7 cbc resume", cnt, 10);
        end else begin
          check(fault == 1'b1, "R4 latched hold low", int'(fault), 1);
          pulse_count(10, 6, cnt);
          check(cnt == 0, "R4 latched pulse blocked", cnt, 0);
          check(fault == 1'b1, "R4 latched after pulse", int'(fault), 1);
        end
      end
    end

    // R6: exact cbc clear edge
    do_reset();
    mode_sel = 1'b1;
    slew_sel = 2'd3;
    tick(4);
    short_count(L3, cnt);
    oc_in = 1'b0;
    pwm_in = 1'b0;
    tick(2);
    check(fault == 1'b1, "R6 clear not before edge3", int'(fault), 1);
    tick(1);
    check(fault == 1'b0, "R6 clear at edge3", int'(fault), 0);

    // R3: trip after blanking, latency of three edges
    do_reset();
    mode_sel = 1'b0;
    slew_sel = 2'd0;
    tick(4);
    pwm_in = 1'b1;
    tick(L0 + 8);
    check(gate_en == 1'b1, "R3 gate on before trip", int'(gate_en), 1);
    oc_in = 1'b1;
    tick(2);
    check(gate_en == 1'b1, "R3 gate still on edge2", int'(gate_en), 1);
    tick(1);
    check(gate_en == 1'b0, "R3 gate off edge3", int'(gate_en), 0);
    check(fault == 1'b1, "R3 fault set", int'(fault), 1);

    // R8 then R5: short pulse restarts low-time count
    oc_in = 1'b0;
    pwm_in = 1'b0;
    tick(LOWC - 10);
    pwm_in = 1'b1;
    tick(3);
    check(gate_en == 1'b0, "R8 gate blocked in pulse", int'(gate_en), 0);
    pwm_in = 1'b0;
    tick(LOWC + 1);
    check(fault == 1'b1, "R8 fault kept before full count", int'(fault), 1);
    tick(1);
    check(fault == 1'b0, "R5 latched release", int'(fault), 0);
    tick(4);
    pulse_count(8, 6, cnt);
    check(cnt == 8, "R5 resume after release", cnt, 8);

    // R9: reset releases a latched fault
    slew_sel = 2'd2;
    tick(4);
    short_count(L2, cnt);
    check(fault == 1'b1, "R9 fault before reset", int'(fault), 1);
    rst = 1'b1;
    tick(1);
    check(fault == 1'b0, "R9 reset clears fault", int'(fault), 0);
    check(gate_en == 1'b0, "R9 reset clears gate", int'(gate_en), 0);
    do_reset();

    // R10: transient slew change while gate is on has no effect
    mode_sel = 1'b1;
    slew_sel = 2'd0;
    tick(4);
    pwm_in = 1'b1;
    tick(5);
    slew_sel = 2'd3;
    tick(3);
    slew_sel = 2'd0;
    tick(2);
    pwm_in = 1'b0;
    tick(6);
    short_count(L0, cnt);
    check(cnt == L0, "R10 slew ignored while on", cnt, L0);
    oc_in = 1'b0;
    pwm_in = 1'b0;
    tick(6);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule